// File: doc/BRIEF.md
# Paced Counter Test-Pattern Source

This block stands in for a multi-channel converter when the acquisition path runs in its throughput-test mode. It emits frames of eight 32-bit words. Each word carries a 24-bit payload taken from a free-running counter in its low bits and a one-hot channel tag in its top byte, so the downstream ring buffer writer sees the same word layout it would see from live conversions. Every word of a frame takes the next counter value, and the counter is tested for its wrap value once per frame, after the frame's last word.

Frames are paced by a programmable interval, counted in clock cycles from the first word of one frame to the first word of the next. This lets software set the frame rate to match the real converter (about 10547 frames per second). The source is active only while the run-mode input carries the test code. Outside that code it holds its output idle and its counter at zero. Words leave through a valid/ready handshake, and a low ready stalls the source without losing or changing a word.

Top module: `tpat_source`

## Requirements
- R1: While `run_mode` differs from the test code (test = 2, normal run = 1, idle = 0), and during reset, `word_valid` is low from the next cycle on, and the counter is held at zero.
- R2: Word k of a frame (k = 0..7) carries payload `base + k` in bits 23:0, where `base` is the counter value at frame start. The counter advances by one per accepted word, modulo 2^24, and continues from frame to frame.
- R3: Bits 31:24 of word k hold the one-hot tag `1 << k` (0x01 for the first word up to 0x80 for the eighth). `word_last` is high exactly while the word tagged 0x80 is presented.
- R4: When the last word of a frame is accepted and the advanced counter equals the parameter `WRAP_LIMIT` (default 0xFFFFFF), the counter becomes zero. The counter is compared against the limit only at that frame boundary.
- R5: The first word of a frame is presented no sooner than `pace_cycles` cycles after the first word of the previous frame. With ready held high, the next frame starts at the later of that point and the cycle after the previous frame's last word is accepted.
- R6: While `word_valid` is high and `word_ready` is low, the next cycle presents the same `word_data` with `word_valid` still high.
- R7: On entry into test mode the first frame is not held back by pacing. `word_valid` rises in the second cycle after `run_mode` takes the test code, with data 0x01000000.
- R8: Leaving test mode in the middle of a frame drops `word_valid` after one clock edge and abandons the frame. Re-entry restarts at word 0 with payload 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_mode | input | 2 | Run-state code; the source runs only on the test code (2) |
| pace_cycles | input | 16 | Frame-start-to-frame-start interval in cycles |
| word_ready | input | 1 | Consumer accepts the presented word |
| word_data | output | 32 | Tag in 31:24, counter payload in 23:0 |
| word_valid | output | 1 | A word is presented |
| word_last | output | 1 | Presented word is the last of its frame |

## Verification
The interesting collision is the frame boundary. There, in one cycle, the last word is accepted, the counter is compared against its wrap limit and reset, and the pacing timer launches the next frame. The bench provokes this by overriding the wrap limit to 40, which makes a reset happen every fifth frame, and by setting the pace interval below the frame length so that frames run back to back. It judges the result by requiring that the word after payload 39, which must carry the 0x80 tag, is the next frame's first word with payload 0, and that frame starts stay exactly eight cycles apart. A behavioural model in the bench also checks every cycle under random ready stalls and mid-frame mode exits.

// File: rtl/tpat_pkg.sv
package tpat_pkg;
   typedef enum logic [1:0] {
      RUN_IDLE   = 2'd0,
      RUN_NORMAL = 2'd1,
      RUN_TEST   = 2'd2
   } run_code_e;
endpackage

// File: rtl/tpat_pacer.sv
// Interval timer measured from one frame launch to the next.
module tpat_pacer #(
   parameter int PACE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              launch,
   input  logic [PACE_W-1:0] pace_cycles,
   output logic              pace_ok
);
   localparam logic [PACE_W-1:0] SAT = '1;

   logic [PACE_W-1:0] elapsed_q;

   // Saturated while idle so the first frame after entry is not delayed.
   always_ff @(posedge clk) begin
      if (!rst_n || clear)         elapsed_q <= SAT;
      else if (launch)             elapsed_q <= PACE_W'(1);
      else if (elapsed_q != SAT)   elapsed_q <= elapsed_q + PACE_W'(1);
   end

   assign pace_ok = (elapsed_q >= pace_cycles);
endmodule

// File: rtl/tpat_word_seq.sv
// Word position within a frame and the payload counter with frame-boundary wrap test.
module tpat_word_seq #(
   parameter int FRAME_WORDS = 8,
   parameter int CNT_W       = 24,
   parameter logic [CNT_W-1:0] WRAP_LIMIT = '1,
   localparam int IDX_W      = $clog2(FRAME_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   output logic [IDX_W-1:0] idx,
   output logic [CNT_W-1:0] count,
   output logic             at_last
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);
   localparam bit POW2 = ((1 << IDX_W) == FRAME_WORDS);

   logic [IDX_W-1:0] idx_q, idx_nxt;
   logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_nxt;

   assign at_last = (idx_q == LAST_IDX);
   assign cnt_inc = cnt_q + CNT_W'(1);

   generate
      if (POW2) begin : g_idx_wrap_free
         assign idx_nxt = idx_q + IDX_W'(1);
      end else begin : g_idx_wrap_cmp
         assign idx_nxt = at_last ? '0 : idx_q + IDX_W'(1);
      end
   endgenerate

   // Wrap limit compared only after the frame's last word.
   always_comb begin
      cnt_nxt = cnt_inc;
      if (at_last && (cnt_inc == WRAP_LIMIT)) cnt_nxt = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         idx_q <= '0;
         cnt_q <= '0;
      end else if (advance) begin
         idx_q <= idx_nxt;
         cnt_q <= cnt_nxt;
      end
   end

   assign idx   = idx_q;
   assign count = cnt_q;
endmodule

// File: rtl/tpat_tagger.sv
// One-hot channel tag from word position.
module tpat_tagger #(
   parameter int FRAME_WORDS = 8,
   parameter int TAG_W       = 8,
   localparam int IDX_W      = $clog2(FRAME_WORDS)
) (
   input  logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag
);
   for (genvar g = 0; g < TAG_W; g++) begin : g_bit
      if (g < FRAME_WORDS) begin : g_used
         assign tag[g] = (idx == IDX_W'(g));
      end else begin : g_spare
         assign tag[g] = 1'b0;
      end
   end
endmodule

// File: rtl/tpat_source.sv
module tpat_source #(
   parameter int DATA_W      = 32,
   parameter int TAG_W       = 8,
   parameter int FRAME_WORDS = 8,
   parameter int MODE_W      = 2,
   parameter logic [MODE_W-1:0] TEST_CODE = MODE_W'(tpat_pkg::RUN_TEST),
   parameter int PACE_W      = 16,
   parameter logic [DATA_W-TAG_W-1:0] WRAP_LIMIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] run_mode,
   input  logic [PACE_W-1:0] pace_cycles,
   input  logic              word_ready,
   output logic [DATA_W-1:0] word_data,
   output logic              word_valid,
   output logic              word_last
);
   localparam int PAYLOAD_W = DATA_W - TAG_W;
   localparam int IDX_W     = $clog2(FRAME_WORDS);

   generate
      if (FRAME_WORDS < 2)       begin : g_chk_words $error("FRAME_WORDS must be at least 2"); end
      if (TAG_W < FRAME_WORDS)   begin : g_chk_tag   $error("TAG_W too narrow for one-hot tags"); end
      if (PAYLOAD_W < 1)         begin : g_chk_data  $error("DATA_W must exceed TAG_W"); end
      if (PACE_W < 1)            begin : g_chk_pace  $error("PACE_W must be positive"); end
   endgenerate

   logic                 in_test;
   logic                 busy_q;
   logic                 accept, frame_end, slot_free, launch, pace_ok;
   logic [IDX_W-1:0]     idx;
   logic [PAYLOAD_W-1:0] count;
   logic                 at_last;
   logic [TAG_W-1:0]     tag;

   assign in_test   = (run_mode == TEST_CODE);
   assign accept    = busy_q && word_ready;
   assign frame_end = accept && at_last;
   assign slot_free = !busy_q || frame_end;
   assign launch    = in_test && slot_free && pace_ok;

   always_ff @(posedge clk) begin
      if (!rst_n || !in_test) busy_q <= 1'b0;
      else if (launch)        busy_q <= 1'b1;
      else if (frame_end)     busy_q <= 1'b0;
   end

   tpat_pacer #(.PACE_W(PACE_W)) u_pacer (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (!in_test),
      .launch      (launch),
      .pace_cycles (pace_cycles),
      .pace_ok     (pace_ok)
   );

   tpat_word_seq #(
      .FRAME_WORDS (FRAME_WORDS),
      .CNT_W       (PAYLOAD_W),
      .WRAP_LIMIT  (WRAP_LIMIT)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (!in_test),
      .advance (accept),
      .idx     (idx),
      .count   (count),
      .at_last (at_last)
   );

   tpat_tagger #(.FRAME_WORDS(FRAME_WORDS), .TAG_W(TAG_W)) u_tag (
      .idx (idx),
      .tag (tag)
   );

   assign word_data  = {tag, count};
   assign word_valid = busy_q;
   assign word_last  = busy_q && at_last;
endmodule

// File: rtl/tpat_source_chk.sv
module tpat_source_chk #(
   parameter int DATA_W      = 32,
   parameter int TAG_W       = 8,
   parameter int FRAME_WORDS = 8,
   parameter int MODE_W      = 2,
   parameter logic [MODE_W-1:0] TEST_CODE = 2,
   parameter int PACE_W      = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [MODE_W-1:0] run_mode,
   input logic [PACE_W-1:0] pace_cycles,
   input logic              word_ready,
   input logic [DATA_W-1:0] word_data,
   input logic              word_valid,
   input logic              word_last
);
   localparam int PAYLOAD_W = DATA_W - TAG_W;
   localparam logic [PACE_W-1:0] SAT = '1;

   logic              in_test, prev_stall_q, seen_q, start_evt;
   logic [PACE_W-1:0] gap_q;

   assign in_test   = (run_mode == TEST_CODE);
   assign start_evt = word_valid && word_data[PAYLOAD_W] && !prev_stall_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_stall_q <= 1'b0;
         seen_q       <= 1'b0;
         gap_q        <= SAT;
      end else begin
         prev_stall_q <= word_valid && !word_ready;
         if (!in_test) begin
            seen_q <= 1'b0;
            gap_q  <= SAT;
         end else if (start_evt) begin
            seen_q <= 1'b1;
            gap_q  <= PACE_W'(1);
         end else if (gap_q != SAT) begin
            gap_q  <= gap_q + PACE_W'(1);
         end
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_test |=> !word_valid);  // R1
   AST_TAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> ($countones(word_data[DATA_W-1:PAYLOAD_W]) == 1));  // R3
   AST_LAST_TOP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (word_last == word_data[PAYLOAD_W+FRAME_WORDS-1]));  // R3
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && !word_ready && in_test) |=> (word_valid && $stable(word_data)));  // R6
   AST_PACE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt && seen_q) |-> (gap_q >= pace_cycles));  // R5
   AST_ENTRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt && !seen_q) |-> (word_data[PAYLOAD_W-1:0] == '0));  // R7
endmodule

bind tpat_source tpat_source_chk #(
   .DATA_W      (DATA_W),
   .TAG_W       (TAG_W),
   .FRAME_WORDS (FRAME_WORDS),
   .MODE_W      (MODE_W),
   .TEST_CODE   (TEST_CODE),
   .PACE_W      (PACE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run_mode    (run_mode),
   .pace_cycles (pace_cycles),
   .word_ready  (word_ready),
   .word_data   (word_data),
   .word_valid  (word_valid),
   .word_last   (word_last)
);

// File: tb/sim_tpat_source.sv
`timescale 1ns/1ps
module sim_tpat_source;
   localparam logic [23:0] WRAP = 24'd40;
   localparam int BIG = 1000000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  run_mode = 2'd0;
   logic [15:0] pace_cycles = 16'd20;
   logic        word_ready = 1'b1;
   logic [31:0] word_data;
   logic        word_valid, word_last;

   always #5 clk = ~clk;

   tpat_source #(.WRAP_LIMIT(WRAP)) u0 (
      .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .pace_cycles(pace_cycles),
      .word_ready(word_ready), .word_data(word_data), .word_valid(word_valid),
      .word_last(word_last)
   );

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s cycle=%0d actual=%h expected=%h", req, cyc, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // Behavioural reference model, advanced on each rising edge.
   bit          m_valid = 0;
   int          m_idx = 0, m_since = BIG;
   logic [23:0] m_cnt = '0;
   always @(posedge clk) begin
      bit acc, fin;
      if (!rst_n || run_mode != 2'd2) begin
         m_valid = 0; m_idx = 0; m_cnt = '0; m_since = BIG;
      end else begin
         acc = m_valid && word_ready;
         fin = 0;
         if (acc) begin
            m_cnt = m_cnt + 24'd1;
            if (m_idx == 7) begin
               fin = 1;
               m_idx = 0;
               if (m_cnt == WRAP) m_cnt = '0;
            end else m_idx++;
         end
         if ((!m_valid || fin) && m_since >= int'(pace_cycles)) begin
            m_valid = 1; m_idx = 0; m_since = 1;
         end else begin
            if (fin) m_valid = 0;
            if (m_since < BIG) m_since++;
         end
      end
   end

   // Monitor: compares away from the active edge.
   logic [31:0] acc_q[$];
   int          starts_q[$];
   bit          prev_stall = 0, st_pend = 0;
   logic [31:0] st_data;
   always @(negedge clk) begin
      cyc++;
      chk(word_valid == m_valid, "R5 valid", 32'(word_valid), 32'(m_valid));
      if (m_valid) begin
         chk(word_data == {8'(1 << m_idx), m_cnt}, "R2 data", word_data, {8'(1 << m_idx), m_cnt});
         chk(word_last == (m_idx == 7), "R3 last", 32'(word_last), 32'(m_idx == 7));
      end
      if (st_pend) chk(word_valid && word_data == st_data, "R6 stall hold", word_data, st_data);
      st_pend = word_valid && !word_ready && run_mode == 2'd2;
      st_data = word_data;
      if (word_valid && word_data[31:24] == 8'h01 && !prev_stall) starts_q.push_back(cyc);
      if (word_valid && word_ready) acc_q.push_back(word_data);
      prev_stall = word_valid && !word_ready;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      finish_run();
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      int vcount;
      // Reset state
      step(4);
      @(negedge clk);
      chk(!word_valid, "R1 reset", 32'(word_valid), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      // Normal-run code: nothing produced
      run_mode = 2'd1;
      vcount = 0;
      repeat (20) begin @(negedge clk); if (word_valid) vcount++; end
      chk(vcount == 0, "R1 normal code quiet", vcount, 0);

      // Entry into test mode, pace 20
      @(posedge clk); #1;
      starts_q.delete(); acc_q.delete();
      run_mode = 2'd2;
      @(negedge clk);
      chk(!word_valid, "R7 entry latency", 32'(word_valid), 0);
      @(negedge clk);
      chk(word_valid && word_data == 32'h0100_0000, "R7 entry word", word_data, 32'h0100_0000);
      step(120);
      chk(starts_q[1] - starts_q[0] == 20, "R5 pace gap", starts_q[1] - starts_q[0], 20);
      chk(starts_q[2] - starts_q[1] == 20, "R5 pace gap", starts_q[2] - starts_q[1], 20);
      for (int i = 0; i < 16; i++)
         chk(acc_q[i] == {8'(1 << (i % 8)), 24'(i)}, "R2 consecutive", acc_q[i], {8'(1 << (i % 8)), 24'(i)});

      // Back-to-back frames with wrap at the boundary
      pace_cycles = 16'd3;
      step(30);
      starts_q.delete(); acc_q.delete();
      step(100);
      chk(starts_q[1] - starts_q[0] == 8, "R5 back-to-back", starts_q[1] - starts_q[0], 8);
      chk(starts_q[2] - starts_q[1] == 8, "R5 back-to-back", starts_q[2] - starts_q[1], 8);
      vcount = 0;
      for (int i = 0; i + 1 < acc_q.size(); i++) begin
         if (acc_q[i][23:0] == 24'd39) begin
            vcount++;
            chk(acc_q[i][31:24] == 8'h80, "R4 wrap at last word", acc_q[i], {8'h80, 24'd39});
            chk(acc_q[i+1] == 32'h0100_0000, "R4 wrap to zero", acc_q[i+1], 32'h0100_0000);
         end
      end
      chk(vcount >= 2, "R4 wrap seen", vcount, 2);

      // Random back-pressure
      pace_cycles = 16'd10;
      for (int i = 0; i < 400; i++) begin
         word_ready = 1'($urandom_range(0, 1));
         step(1);
      end
      word_ready = 1'b1;

      // Mid-frame exit and re-entry
      do @(negedge clk); while (!(word_valid && word_data[27]));
      @(posedge clk); #1 run_mode = 2'd1;
      @(negedge clk);
      chk(word_valid, "R8 exit one edge later", 32'(word_valid), 1);
      @(negedge clk);
      chk(!word_valid, "R8 exit drops valid", 32'(word_valid), 0);
      step(5);
      run_mode = 2'd2;
      @(negedge clk);
      @(negedge clk);
      chk(word_valid && word_data == 32'h0100_0000, "R8 re-entry restart", word_data, 32'h0100_0000);
      step(60);
      finish_run();
   end
endmodule